// File: doc/BRIEF.md
# Page Write Buffer and Commit Sequencer

This block sits behind the byte-level front end of a two-wire serial memory slave. After the word address arrives it collects the data bytes of one write transaction into a small page buffer. It indexes the buffer with the low bits of a byte pointer. When the closing STOP strobe arrives it copies the buffered bytes into an external byte array through a simple write port. It then holds a busy flag for a fixed, parameterised write time. While that flag is high the front end refuses new traffic, which gives the acknowledge polling that the bus relies on.

Only the low pointer bits advance, so a long burst wraps inside its own page and overwrites earlier entries. Each buffer slot carries a valid flag, so only the bytes actually sent reach the array. The write-protect input is captured with STOP. A protected transaction still runs the full busy time but issues no array writes.

Top module: `pageWriteCommit`

## Requirements
- R1: After reset `busy` is 0, `arrWrEn` is 0 and no buffer slot holds data.
- R2: A `dataValid` strobe while not busy stores `dataIn` in slot `ptr[PAGE_W-1:0]`. It then advances only those low pointer bits, so `ptr[7:4]` never changes and writing past the last byte of a 16-byte page continues at the first byte of the same page.
- R3: When more than 16 bytes arrive before STOP, each slot keeps the last byte written to it, so the array receives only the final 16 bytes.
- R4: A `stopSeen` strobe while not busy, with at least one byte buffered, raises `busy` on the next clock edge. `busy` then stays high for exactly `WRITE_CYCLES` cycles.
- R5: In busy cycle i (counted from 0), for i below 16, the block pulses `arrWrEn` with address `{ptr[7:4], i}` and the byte in slot i, and only if slot i is valid. Addresses of the page that were not sent receive no write.
- R6: When `writeProtect` is 1 in the STOP cycle, no `arrWrEn` pulse occurs, but `busy` still lasts the full `WRITE_CYCLES`.
- R7: A STOP with no data byte buffered leaves `busy` low and causes no array write.
- R8: `dataValid`, `addrLoad` and `stopSeen` are ignored while `busy` is high. All valid flags clear when the write cycle ends.
- R9: `addrLoad` while not busy sets all eight pointer bits to `addrIn`. Without a new load, the pointer carries over from one transaction to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addrLoad | input | 1 | Word-address load strobe |
| addrIn | input | 8 | Word address |
| dataValid | input | 1 | Data byte strobe |
| dataIn | input | 8 | Data byte |
| stopSeen | input | 1 | STOP condition strobe |
| writeProtect | input | 1 | Write protect, sampled with STOP |
| busy | output | 1 | Write cycle in progress |
| arrWrEn | output | 1 | Array write enable |
| arrWrAddr | output | 8 | Array write address |
| arrWrData | output | 8 | Array write data |

## Verification
The hardest state to reach is traffic arriving in the middle of a write cycle, followed by a transaction that must prove nothing from that traffic survived. The stimulus starts a commit and, while `busy` is high, issues a data byte, an address load and a second STOP. Once the cycle ends it sends a bare STOP, which must not start a cycle because the valid flags were cleared. It then sends one byte without reloading the address. That byte must land at the pointer value from before the busy window, and it must be the only byte written.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic capture;     // store dataIn, advance low pointer bits
    logic loadPtr;     // replace pointer with addrIn
    logic commitRun;   // commit slot selected by commitIdx
    logic clearFlags;  // write cycle ends: drop all valid flags
  } pwcCtrl_t;
endpackage

// File: rtl/pwc_ctrl.sv
module pwc_ctrl
  import pwc_pkg::*;
#(
  parameter int PAGE_W       = 4,
  parameter int WRITE_CYCLES = 2500000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dataValid,
  input  logic              addrLoad,
  input  logic              stopSeen,
  input  logic              writeProtect,
  input  logic              anyValid,
  output pwcCtrl_t          ctrl,
  output logic [PAGE_W-1:0] commitIdx,
  output logic              busy
);
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int CNT_W      = $clog2(WRITE_CYCLES + 1);

  logic [CNT_W-1:0] cycleCnt;
  logic             wpHold;
  logic             lastCycle;

  assign lastCycle = busy && (cycleCnt == CNT_W'(WRITE_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      cycleCnt <= '0;
      wpHold   <= 1'b0;
    end else if (busy) begin
      if (lastCycle) begin
        busy     <= 1'b0;
        cycleCnt <= '0;
      end else begin
        cycleCnt <= cycleCnt + 1'b1;
      end
    end else if (stopSeen && anyValid) begin
      busy     <= 1'b1;
      cycleCnt <= '0;
      wpHold   <= writeProtect;
    end
  end

  always_comb begin
    ctrl.capture    = dataValid && !busy;
    ctrl.loadPtr    = addrLoad && !busy;
    ctrl.commitRun  = busy && !wpHold && (cycleCnt < CNT_W'(PAGE_BYTES));
    ctrl.clearFlags = lastCycle;
    commitIdx       = cycleCnt[PAGE_W-1:0];
  end
endmodule

// File: rtl/pwc_data.sv
module pwc_data
  import pwc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  pwcCtrl_t          ctrl,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [PAGE_W-1:0] commitIdx,
  output logic              anyValid,
  output logic              arrWrEn,
  output logic [ADDR_W-1:0] arrWrAddr,
  output logic [DATA_W-1:0] arrWrData
);
  localparam int PAGE_BYTES = 1 << PAGE_W;

  logic [ADDR_W-1:0]     ptr;
  logic [DATA_W-1:0]     slotData [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] slotValid;
  logic [PAGE_BYTES-1:0] slotHit;

  // one-hot slot select from the low pointer bits
  for (genvar g = 0; g < PAGE_BYTES; g++) begin : gHit
    assign slotHit[g] = ctrl.capture && (ptr[PAGE_W-1:0] == PAGE_W'(g));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (ctrl.loadPtr) begin
      ptr <= addrIn;
    end else if (ctrl.capture) begin
      ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotValid <= '0;
    end else if (ctrl.clearFlags) begin
      slotValid <= '0;
    end else begin
      slotValid <= slotValid | slotHit;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < PAGE_BYTES; i++) begin
      if (slotHit[i]) slotData[i] <= dataIn;
    end
  end

  assign anyValid  = |slotValid;
  assign arrWrEn   = ctrl.commitRun && slotValid[commitIdx];
  assign arrWrAddr = {ptr[ADDR_W-1:PAGE_W], commitIdx};
  assign arrWrData = slotData[commitIdx];
endmodule

// File: rtl/pageWriteCommit.sv
module pageWriteCommit
  import pwc_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 8,
  parameter int PAGE_W       = 4,
  parameter int WRITE_CYCLES = 2500000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrLoad,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              dataValid,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              stopSeen,
  input  logic              writeProtect,
  output logic              busy,
  output logic              arrWrEn,
  output logic [ADDR_W-1:0] arrWrAddr,
  output logic [DATA_W-1:0] arrWrData
);
  pwcCtrl_t          ctrl;
  logic [PAGE_W-1:0] commitIdx;
  logic              anyValid;

  pwc_ctrl #(.PAGE_W(PAGE_W), .WRITE_CYCLES(WRITE_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .dataValid(dataValid), .addrLoad(addrLoad),
    .stopSeen(stopSeen), .writeProtect(writeProtect), .anyValid(anyValid),
    .ctrl(ctrl), .commitIdx(commitIdx), .busy(busy)
  );

  pwc_data #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_data (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .addrIn(addrIn), .dataIn(dataIn),
    .commitIdx(commitIdx), .anyValid(anyValid), .arrWrEn(arrWrEn),
    .arrWrAddr(arrWrAddr), .arrWrData(arrWrData)
  );
endmodule

// File: rtl/pwc_checker.sv
module pwc_checker #(
  parameter int ADDR_W       = 8,
  parameter int PAGE_W       = 4,
  parameter int WRITE_CYCLES = 2500000
) (
  input logic              clk,
  input logic              rstN,
  input logic              dataValid,
  input logic              stopSeen,
  input logic              writeProtect,
  input logic              busy,
  input logic              arrWrEn,
  input logic [ADDR_W-1:0] arrWrAddr
);
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int RUN_W      = $clog2(WRITE_CYCLES + 1) + 1;

  logic [RUN_W-1:0] busyRun;
  logic             wpSeen;
  logic             dataSince;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyRun   <= '0;
      wpSeen    <= 1'b0;
      dataSince <= 1'b0;
    end else begin
      busyRun <= busy ? busyRun + 1'b1 : '0;
      if (stopSeen && !busy) wpSeen <= writeProtect;
      if (busy) dataSince <= 1'b0;
      else if (dataValid) dataSince <= 1'b1;
    end
  end

  a_r1_idle_after_reset: assert property (@(posedge clk)
    $rose(rstN) |-> !busy && !arrWrEn);

  a_r4_busy_length: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> busyRun == RUN_W'(WRITE_CYCLES));

  a_r4_starts: assert property (@(posedge clk) disable iff (!rstN)
    (stopSeen && !busy && dataSince) |=> busy);

  a_r7_bare_stop: assert property (@(posedge clk) disable iff (!rstN)
    (stopSeen && !busy && !dataSince) |=> !busy);

  a_r6_protect: assert property (@(posedge clk) disable iff (!rstN)
    arrWrEn |-> !wpSeen);

  a_r5_slot_order: assert property (@(posedge clk) disable iff (!rstN)
    arrWrEn |-> busy && (busyRun < RUN_W'(PAGE_BYTES))
                && (arrWrAddr[PAGE_W-1:0] == busyRun[PAGE_W-1:0]));

  a_r2_same_page: assert property (@(posedge clk) disable iff (!rstN)
    (arrWrEn && $past(arrWrEn)) |->
      arrWrAddr[ADDR_W-1:PAGE_W] == $past(arrWrAddr[ADDR_W-1:PAGE_W]));
endmodule

bind pageWriteCommit pwc_checker #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WRITE_CYCLES(WRITE_CYCLES)
) u_chk (
  .clk(clk), .rstN(rstN), .dataValid(dataValid), .stopSeen(stopSeen),
  .writeProtect(writeProtect), .busy(busy), .arrWrEn(arrWrEn),
  .arrWrAddr(arrWrAddr)
);

// File: tb/pageWriteCommit_tb.sv
module pageWriteCommit_tb;
  localparam int WC = 40;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       addrLoad = 1'b0;
  logic [7:0] addrIn = '0;
  logic       dataValid = 1'b0;
  logic [7:0] dataIn = '0;
  logic       stopSeen = 1'b0;
  logic       writeProtect = 1'b0;
  logic       busy, arrWrEn;
  logic [7:0] arrWrAddr, arrWrData;

  always #2 clk = ~clk;

  pageWriteCommit #(.WRITE_CYCLES(WC)) u_dut (
    .clk(clk), .rstN(rstN), .addrLoad(addrLoad), .addrIn(addrIn),
    .dataValid(dataValid), .dataIn(dataIn), .stopSeen(stopSeen),
    .writeProtect(writeProtect), .busy(busy), .arrWrEn(arrWrEn),
    .arrWrAddr(arrWrAddr), .arrWrData(arrWrData)
  );

  int tests = 0;
  int fails = 0;
  bit done = 0;

  logic [15:0] expQ[$];
  logic [7:0]  mBuf [16];
  logic [15:0] mVal = '0;
  logic [7:0]  mPtr = '0;
  bit          mBusy = 0;
  int          runLen = 0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // monitor: scoreboard pop on each array write, busy length per run
  always @(negedge clk) begin
    if (rstN) begin
      if (arrWrEn) begin
        if (expQ.size() == 0) begin
          check(0, "R5", "unexpected array write addr", int'(arrWrAddr), 0);
        end else begin
          logic [15:0] e;
          e = expQ.pop_front();
          check({arrWrAddr, arrWrData} == e, "R5", "array write addr/data",
                int'({arrWrAddr, arrWrData}), int'(e));
        end
      end
      if (busy) runLen++;
      else if (runLen != 0) begin
        check(runLen == WC, "R4", "busy length", runLen, WC);
        runLen = 0;
      end
    end
  end

  // drivers: called just after a falling edge, return after the next one
  task automatic loadAddr(input logic [7:0] a);
    addrLoad = 1'b1; addrIn = a;
    if (!mBusy) mPtr = a;
    @(negedge clk);
    addrLoad = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] d);
    dataValid = 1'b1; dataIn = d;
    if (!mBusy) begin
      mBuf[mPtr[3:0]] = d;
      mVal[mPtr[3:0]] = 1'b1;
      mPtr[3:0] = mPtr[3:0] + 4'd1;
    end
    @(negedge clk);
    dataValid = 1'b0;
  endtask

  task automatic stopPulse(input string req);
    bit wasBusy, start;
    wasBusy = mBusy;
    start = !mBusy && (mVal != 0);
    stopSeen = 1'b1;
    if (start) begin
      if (!writeProtect)
        for (int i = 0; i < 16; i++)
          if (mVal[i]) expQ.push_back({mPtr[7:4], 4'(i), mBuf[i]});
      mVal = '0;
      mBusy = 1;
    end
    @(negedge clk);
    stopSeen = 1'b0;
    if (wasBusy) check(busy == 1'b1, "R8", "busy during ignored stop", int'(busy), 1);
    else check(busy == start, req, "busy after stop", int'(busy), int'(start));
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
    mBusy = 0;
    @(negedge clk);
    check(expQ.size() == 0, "R5", "pending expected writes", expQ.size(), 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);
    check(arrWrEn == 1'b0, "R1", "write enable in reset", int'(arrWrEn), 0);
    rstN = 1'b1;
    @(negedge clk);
    // R7 right after reset: no slot holds data
    stopPulse("R7");
    check(busy == 1'b0, "R1", "busy after bare stop", int'(busy), 0);

    // R2/R5 single byte
    loadAddr(8'h35); sendByte(8'hA5); stopPulse("R4"); waitIdle();

    // R9 pointer carries over: next byte lands at 0x36
    sendByte(8'h11); stopPulse("R4"); waitIdle();

    // R9 last load wins
    loadAddr(8'h90); loadAddr(8'hC2); sendByte(8'h21); sendByte(8'h22);
    stopPulse("R4"); waitIdle();

    // R2 wrap inside page 0x70
    loadAddr(8'h7C);
    for (int i = 0; i < 6; i++) sendByte(8'h60 + 8'(i));
    stopPulse("R4"); waitIdle();

    // R3 twenty bytes: last sixteen survive
    loadAddr(8'h20);
    for (int i = 0; i < 20; i++) sendByte(8'hB0 + 8'(i));
    stopPulse("R4"); waitIdle();

    // R6 protected: no writes, full busy
    loadAddr(8'h50); writeProtect = 1'b1;
    sendByte(8'h01); sendByte(8'h02); sendByte(8'h03);
    stopPulse("R6"); writeProtect = 1'b0; waitIdle();

    // R7 address only, then stop
    loadAddr(8'hE0); stopPulse("R7");
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R7", "busy after address-only stop", int'(busy), 0);

    // R8 traffic during busy is ignored, flags cleared at end
    loadAddr(8'h40); sendByte(8'h5A); stopPulse("R4");
    sendByte(8'hEE); loadAddr(8'h00); stopPulse("R8");
    waitIdle();
    stopPulse("R8");
    check(busy == 1'b0, "R8", "stale flag started cycle", int'(busy), 0);
    sendByte(8'h77); stopPulse("R8"); waitIdle();

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R5", "leftover expected writes", expQ.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule